// File: doc/BRIEF.md
# Clock Stop and Power-Down Gating Controller

This block decides, for every output of a multi-domain clock generator, whether that output is running or stopped, and produces the gated clock for each one. It combines three active-low control pins with per-output configuration bits. The pins are power-down, CPU stop and PCI stop. The configuration bits are output enables, free-running selections for the CPU pairs, stop-enable selections for the free-running PCI outputs, and a power-down three-state option for the CPU pairs. The pins are asynchronous and are brought into the fast reference domain through a multi-flop synchroniser.

Each output group receives a divided source clock as a level that is generated in the fast reference domain. The output groups are the CPU pairs, the free-running PCI outputs, the stoppable PCI outputs, the 66 MHz outputs, the buffered 66 MHz outputs, and the two 48 MHz outputs. A gate cell per output changes its run state only on a fast-clock edge where its source is low, so that no clock high phase is ever cut short or started late. Each differential CPU pair also reports a two-bit drive-mode code that tells the analog driver how to behave when the pair is not toggling.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While the synchronised power-down pin is low, every gated clock output is held low. Each CPU drive code is 01 (true driven at high current, complement floating), or 10 (three-state) when `cpu_pd_hiz` is 1.
- R2: While power is up and the synchronised CPU stop pin is low, CPU pair i is stopped with drive code 01 unless `cpu_free[i]` is 1, in which case it keeps running.
- R3: While power is up and the synchronised PCI stop pin is low, every stoppable PCI output is held low.
- R4: While power is up and the synchronised PCI stop pin is low, free-running PCI output j keeps running when `pcif_stop_en[j]` is 0 and is held low when it is 1.
- R5: The 66 MHz, buffered 66 MHz, USB and DOT outputs ignore both stop pins and run whenever power is up and they are enabled.
- R6: An output whose enable bit is 0 is held low. A disabled CPU pair reports drive code 01 while power is up.
- R7: A run state changes only on a fast-clock edge at which that output's source level is low. A gated output therefore rises only together with its source and falls only together with its source.
- R8: The drive code per CPU pair, at bits [2i+1:2i] of `cpu_drv_o`, is 00 when the pair is running, 01 when it is stopped, and 10 when it is three-stated. The code 11 never appears.
- R9: `cpustop_level_o` reports the CPU stop pin level after exactly SYNC_STAGES rising edges of `clk`.
- R10: During reset the synchronisers hold the asserted (low) pin state, all run states are cleared, all gated outputs are low, and each CPU drive code follows R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n | input | 1 | Power-down pin, active low, asynchronous |
| cpustop_n | input | 1 | CPU stop pin, active low, asynchronous |
| pcistop_n | input | 1 | PCI stop pin, active low, asynchronous |
| cpu_src | input | 1 | CPU domain source clock level |
| pci_src | input | 1 | PCI domain source clock level |
| v66_src | input | 1 | 66 MHz domain source clock level |
| usb_src | input | 1 | 48 MHz domain source clock level |
| cpu_oe | input | N_CPU | CPU pair enables |
| cpu_free | input | N_CPU | CPU pair free-running selects |
| cpu_pd_hiz | input | 1 | Three-state CPU pairs during power-down |
| pcif_oe | input | N_PCIF | Free-running PCI output enables |
| pcif_stop_en | input | N_PCIF | Let PCI stop halt each free-running PCI output |
| pci_oe | input | N_PCI | Stoppable PCI output enables |
| v66_oe | input | N_V66 | 66 MHz output enables |
| buf_oe | input | N_BUF | Buffered 66 MHz output enables |
| usb_oe | input | 1 | USB output enable |
| dot_oe | input | 1 | DOT output enable |
| cpu_clk_o | output | N_CPU | Gated CPU clocks |
| cpu_drv_o | output | 2*N_CPU | Drive-mode code per CPU pair |
| pcif_clk_o | output | N_PCIF | Gated free-running PCI clocks |
| pci_clk_o | output | N_PCI | Gated stoppable PCI clocks |
| v66_clk_o | output | N_V66 | Gated 66 MHz clocks |
| buf_clk_o | output | N_BUF | Gated buffered 66 MHz clocks |
| usb_clk_o | output | 1 | Gated USB clock |
| dot_clk_o | output | 1 | Gated DOT clock |
| cpustop_level_o | output | 1 | Synchronised CPU stop level for readback |

## Verification
The critical coincidence is a synchronised stop or power-down transition landing on the same fast-clock edge at which a domain's source level falls or rises. The gate must then either take the new state cleanly on that low phase or defer it to the next one. The bench runs four source domains with unrelated divide ratios (2, 4, 6 and 8) and changes the pins at random edges, so pin changes repeatedly collide with source edges in every domain. Each collision is judged in two ways. A continuous monitor flags any output that falls while its source is still high, or rises while its source was already high. A steady-state comparison against the requirement functions then confirms that the final run state is correct.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

   typedef enum logic [1:0] {
      DRV_RUN  = 2'b00,
      DRV_STOP = 2'b01,
      DRV_HIZ  = 2'b10
   } drv_mode_e;

endpackage

// File: rtl/clkgate_sync.sv
module clkgate_sync #(
   parameter int         WIDTH   = 3,
   parameter int         STAGES  = 2,
   parameter logic       RST_VAL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("clkgate_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("clkgate_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {(STAGES*WIDTH){RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d};
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/clkgate_cell.sv
module clkgate_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic src,
   input  logic want,
   output logic run,
   output logic clk_o
);

   logic run_q;

   // the run state may only move while the source level is low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
      end else if (!src) begin
         run_q <= want;
      end
   end

   assign run   = run_q;
   assign clk_o = src & run_q;

   // R7
   run_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(run_q) |-> $past(!src));

   // R7
   run_load_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !src |=> (run_q == $past(want)));

endmodule

// File: rtl/clkgate_bank.sv
module clkgate_bank #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src,
   input  logic [WIDTH-1:0] want,
   output logic [WIDTH-1:0] run,
   output logic [WIDTH-1:0] clk_o
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("clkgate_bank: WIDTH must be at least 1");
      end
      for (genvar i = 0; i < WIDTH; i++) begin : g_cell
         clkgate_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .src   (src),
            .want  (want[i]),
            .run   (run[i]),
            .clk_o (clk_o[i])
         );
      end
   endgenerate

endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
   parameter int N_CPU       = 2,
   parameter int N_PCIF      = 3,
   parameter int N_PCI       = 6,
   parameter int N_V66       = 2,
   parameter int N_BUF       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pwrdn_n,
   input  logic                cpustop_n,
   input  logic                pcistop_n,
   input  logic                cpu_src,
   input  logic                pci_src,
   input  logic                v66_src,
   input  logic                usb_src,
   input  logic [N_CPU-1:0]    cpu_oe,
   input  logic [N_CPU-1:0]    cpu_free,
   input  logic                cpu_pd_hiz,
   input  logic [N_PCIF-1:0]   pcif_oe,
   input  logic [N_PCIF-1:0]   pcif_stop_en,
   input  logic [N_PCI-1:0]    pci_oe,
   input  logic [N_V66-1:0]    v66_oe,
   input  logic [N_BUF-1:0]    buf_oe,
   input  logic                usb_oe,
   input  logic                dot_oe,
   output logic [N_CPU-1:0]    cpu_clk_o,
   output logic [2*N_CPU-1:0]  cpu_drv_o,
   output logic [N_PCIF-1:0]   pcif_clk_o,
   output logic [N_PCI-1:0]    pci_clk_o,
   output logic [N_V66-1:0]    v66_clk_o,
   output logic [N_BUF-1:0]    buf_clk_o,
   output logic                usb_clk_o,
   output logic                dot_clk_o,
   output logic                cpustop_level_o
);

   import clkgate_pkg::*;

   localparam int N_PINS = 3;
   localparam int N_AUX  = 2;

   generate
      if (N_CPU < 1 || N_PCIF < 1 || N_PCI < 1 || N_V66 < 1 || N_BUF < 1) begin : g_bad_count
         $error("clk_stop_ctrl: every output group needs at least one member");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("clk_stop_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // pin synchronisation: reset holds the asserted (low) level
   logic [N_PINS-1:0] pins_s;

   clkgate_sync #(
      .WIDTH   (N_PINS),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b0)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({pcistop_n, cpustop_n, pwrdn_n}),
      .q     (pins_s)
   );

   logic pd;
   logic cpu_stop;
   logic pci_stop;

   assign pd       = ~pins_s[0];
   assign cpu_stop = ~pins_s[1];
   assign pci_stop = ~pins_s[2];

   assign cpustop_level_o = pins_s[1];

   // requested run state per output
   logic [N_CPU-1:0]  cpu_want;
   logic [N_PCIF-1:0] pcif_want;
   logic [N_PCI-1:0]  pci_want;
   logic [N_V66-1:0]  v66_want;
   logic [N_BUF-1:0]  buf_want;
   logic [N_AUX-1:0]  aux_want;

   always_comb begin
      cpu_want  = pd ? '0 : (cpu_oe & (cpu_stop ? cpu_free : {N_CPU{1'b1}}));
      pcif_want = pd ? '0 : (pcif_oe & (pci_stop ? ~pcif_stop_en : {N_PCIF{1'b1}}));
      pci_want  = (pd || pci_stop) ? '0 : pci_oe;
      v66_want  = pd ? '0 : v66_oe;
      buf_want  = pd ? '0 : buf_oe;
      aux_want  = pd ? '0 : {dot_oe, usb_oe};
   end

   logic [N_CPU-1:0]  cpu_run;
   logic [N_PCIF-1:0] pcif_run;
   logic [N_PCI-1:0]  pci_run;
   logic [N_V66-1:0]  v66_run;
   logic [N_BUF-1:0]  buf_run;
   logic [N_AUX-1:0]  aux_run;
   logic [N_AUX-1:0]  aux_clk;

   clkgate_bank #(.WIDTH(N_CPU)) u_cpu_bank (
      .clk (clk), .rst_n (rst_n), .src (cpu_src),
      .want (cpu_want), .run (cpu_run), .clk_o (cpu_clk_o)
   );

   clkgate_bank #(.WIDTH(N_PCIF)) u_pcif_bank (
      .clk (clk), .rst_n (rst_n), .src (pci_src),
      .want (pcif_want), .run (pcif_run), .clk_o (pcif_clk_o)
   );

   clkgate_bank #(.WIDTH(N_PCI)) u_pci_bank (
      .clk (clk), .rst_n (rst_n), .src (pci_src),
      .want (pci_want), .run (pci_run), .clk_o (pci_clk_o)
   );

   clkgate_bank #(.WIDTH(N_V66)) u_v66_bank (
      .clk (clk), .rst_n (rst_n), .src (v66_src),
      .want (v66_want), .run (v66_run), .clk_o (v66_clk_o)
   );

   clkgate_bank #(.WIDTH(N_BUF)) u_buf_bank (
      .clk (clk), .rst_n (rst_n), .src (v66_src),
      .want (buf_want), .run (buf_run), .clk_o (buf_clk_o)
   );

   clkgate_bank #(.WIDTH(N_AUX)) u_aux_bank (
      .clk (clk), .rst_n (rst_n), .src (usb_src),
      .want (aux_want), .run (aux_run), .clk_o (aux_clk)
   );

   assign usb_clk_o = aux_clk[0];
   assign dot_clk_o = aux_clk[1];

   // drive-mode code per CPU pair, taken from the gated run state
   generate
      for (genvar i = 0; i < N_CPU; i++) begin : g_drv
         drv_mode_e mode;
         always_comb begin
            if (cpu_run[i]) begin
               mode = DRV_RUN;
            end else if (pd && cpu_pd_hiz) begin
               mode = DRV_HIZ;
            end else begin
               mode = DRV_STOP;
            end
         end
         assign cpu_drv_o[2*i +: 2] = mode;
      end
   endgenerate

   // R1
   pd_holds_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pd) && !$past(v66_src)) |-> (v66_run == '0 && buf_run == '0));

   // R3
   pci_stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pci_stop) && !$past(pci_src)) |-> (pci_run == '0));

   // R5
   v66_ignores_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(pd) && !$past(v66_src)) |-> (v66_run == $past(v66_oe)));

endmodule

// File: tb/clk_stop_ctrl_bench.sv
`timescale 1ns/1ps
module clk_stop_ctrl_bench;

   localparam int NC = 2, NF = 3, NP = 6, NV = 2, NB = 3;
   localparam int W  = NC + NF + NP + NV + NB + 2;
   localparam real HALF = 2.0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwrdn_n = 1'b0, cpustop_n = 1'b1, pcistop_n = 1'b1;
   logic [NC-1:0] cpu_oe, cpu_free;
   logic cpu_pd_hiz;
   logic [NF-1:0] pcif_oe, pcif_stop_en;
   logic [NP-1:0] pci_oe;
   logic [NV-1:0] v66_oe;
   logic [NB-1:0] buf_oe;
   logic usb_oe, dot_oe;
   logic [NC-1:0] cpu_clk_o;
   logic [2*NC-1:0] cpu_drv_o;
   logic [NF-1:0] pcif_clk_o;
   logic [NP-1:0] pci_clk_o;
   logic [NV-1:0] v66_clk_o;
   logic [NB-1:0] buf_clk_o;
   logic usb_clk_o, dot_clk_o, cpustop_level_o;

   // source clock levels, all changing on the falling edge of clk
   logic [2:0] cnt = '0;
   logic [2:0] ucnt = '0;
   logic cpu_src, pci_src, v66_src, usb_src;
   assign cpu_src = cnt[0];
   assign v66_src = cnt[1];
   assign pci_src = cnt[2];
   assign usb_src = (ucnt < 3'd3);

   always #(HALF) clk = ~clk;
   always @(negedge clk) begin
      cnt  <= cnt + 3'd1;
      ucnt <= (ucnt == 3'd5) ? 3'd0 : ucnt + 3'd1;
   end

   clk_stop_ctrl u_clk_stop_ctrl (
      .clk (clk), .rst_n (rst_n),
      .pwrdn_n (pwrdn_n), .cpustop_n (cpustop_n), .pcistop_n (pcistop_n),
      .cpu_src (cpu_src), .pci_src (pci_src), .v66_src (v66_src), .usb_src (usb_src),
      .cpu_oe (cpu_oe), .cpu_free (cpu_free), .cpu_pd_hiz (cpu_pd_hiz),
      .pcif_oe (pcif_oe), .pcif_stop_en (pcif_stop_en), .pci_oe (pci_oe),
      .v66_oe (v66_oe), .buf_oe (buf_oe), .usb_oe (usb_oe), .dot_oe (dot_oe),
      .cpu_clk_o (cpu_clk_o), .cpu_drv_o (cpu_drv_o), .pcif_clk_o (pcif_clk_o),
      .pci_clk_o (pci_clk_o), .v66_clk_o (v66_clk_o), .buf_clk_o (buf_clk_o),
      .usb_clk_o (usb_clk_o), .dot_clk_o (dot_clk_o),
      .cpustop_level_o (cpustop_level_o)
   );

   int checks = 0;
   int errors = 0;
   int runts = 0;
   int bad_codes = 0;
   bit mon_en = 1'b0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // expected run states, from the requirements
   function automatic logic [NC-1:0] x_cpu();
      return {NC{pwrdn_n}} & cpu_oe & ({NC{cpustop_n}} | cpu_free);
   endfunction
   function automatic logic [NF-1:0] x_pcif();
      return {NF{pwrdn_n}} & pcif_oe & ({NF{pcistop_n}} | ~pcif_stop_en);
   endfunction
   function automatic logic [NP-1:0] x_pci();
      return {NP{pwrdn_n & pcistop_n}} & pci_oe;
   endfunction
   function automatic logic [NV+NB+1:0] x_other();
      return {(NV+NB+2){pwrdn_n}} & {v66_oe, buf_oe, dot_oe, usb_oe};
   endfunction
   function automatic logic [2*NC-1:0] x_drv();
      logic [NC-1:0]   r;
      logic [2*NC-1:0] d;
      r = x_cpu();
      for (int i = 0; i < NC; i++) begin
         if (r[i])                       d[2*i +: 2] = 2'b00;
         else if (!pwrdn_n && cpu_pd_hiz) d[2*i +: 2] = 2'b10;
         else                            d[2*i +: 2] = 2'b01;
      end
      return d;
   endfunction

   // continuous glitch monitor for R7 and code monitor for R8
   logic [W-1:0] p_o, p_s;
   bit p_valid = 1'b0;
   always @(negedge clk) begin
      logic [W-1:0] o, s;
      #1;
      o = {cpu_clk_o, pcif_clk_o, pci_clk_o, v66_clk_o, buf_clk_o, dot_clk_o, usb_clk_o};
      s = {{NC{cpu_src}}, {NF{pci_src}}, {NP{pci_src}}, {NV{v66_src}}, {NB{v66_src}}, usb_src, usb_src};
      if (rst_n && mon_en && p_valid) begin
         for (int i = 0; i < W; i++) begin
            if (p_o[i] && !o[i] && s[i]) runts++;
            if (!p_o[i] && o[i] && p_s[i]) runts++;
         end
         for (int i = 0; i < NC; i++) begin
            if (cpu_drv_o[2*i +: 2] == 2'b11) bad_codes++;
         end
      end
      p_o = o;
      p_s = s;
      p_valid = rst_n;
   end

   task automatic settle_check(input string tag);
      logic [31:0] a_cpu, e_cpu, a_drv, e_drv, a_f, e_f, a_p, e_p, a_x, e_x;
      bit ok_cpu = 1, ok_drv = 1, ok_f = 1, ok_p = 1, ok_x = 1;
      a_cpu = 0; e_cpu = 0; a_drv = 0; e_drv = 0; a_f = 0; e_f = 0;
      a_p = 0; e_p = 0; a_x = 0; e_x = 0;
      repeat (16) @(negedge clk);
      for (int k = 0; k < 16; k++) begin
         @(negedge clk); #1;
         if (cpu_clk_o !== ({NC{cpu_src}} & x_cpu())) begin
            ok_cpu = 0; a_cpu = 32'(cpu_clk_o); e_cpu = 32'({NC{cpu_src}} & x_cpu());
         end
         if (cpu_drv_o !== x_drv()) begin
            ok_drv = 0; a_drv = 32'(cpu_drv_o); e_drv = 32'(x_drv());
         end
         if (pcif_clk_o !== ({NF{pci_src}} & x_pcif())) begin
            ok_f = 0; a_f = 32'(pcif_clk_o); e_f = 32'({NF{pci_src}} & x_pcif());
         end
         if (pci_clk_o !== ({NP{pci_src}} & x_pci())) begin
            ok_p = 0; a_p = 32'(pci_clk_o); e_p = 32'({NP{pci_src}} & x_pci());
         end
         if ({v66_clk_o, buf_clk_o, dot_clk_o, usb_clk_o} !==
             ({{(NV+NB){v66_src}}, usb_src, usb_src} & x_other())) begin
            ok_x = 0;
            a_x = 32'({v66_clk_o, buf_clk_o, dot_clk_o, usb_clk_o});
            e_x = 32'({{(NV+NB){v66_src}}, usb_src, usb_src} & x_other());
         end
      end
      check(ok_cpu, {tag, " cpu clocks"}, a_cpu, e_cpu);
      check(ok_drv, {tag, " cpu drive code"}, a_drv, e_drv);
      check(ok_f, {tag, " free pci clocks"}, a_f, e_f);
      check(ok_p, {tag, " pci clocks"}, a_p, e_p);
      check(ok_x, {tag, " 66/usb/dot clocks"}, a_x, e_x);
      check(cpustop_level_o === cpustop_n, {tag, " R9 stop level"}, 32'(cpustop_level_o), 32'(cpustop_n));
   endtask

   task automatic defaults();
      cpu_oe = '1; cpu_free = '0; cpu_pd_hiz = 1'b0;
      pcif_oe = '1; pcif_stop_en = '0; pci_oe = '1;
      v66_oe = '1; buf_oe = '1; usb_oe = 1'b1; dot_oe = 1'b1;
      pwrdn_n = 1'b1; cpustop_n = 1'b1; pcistop_n = 1'b1;
   endtask

   initial begin
      #(4.0 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_c10c));
      defaults();
      pwrdn_n = 1'b0;
      cpustop_n = 1'b0;
      repeat (6) @(negedge clk);
      #1;
      // R10 reset state
      check({cpu_clk_o, pcif_clk_o, pci_clk_o, v66_clk_o, buf_clk_o, usb_clk_o, dot_clk_o} == '0,
            "R10 reset outputs low", 32'({cpu_clk_o, pcif_clk_o, pci_clk_o}), 0);
      check(cpu_drv_o == 4'b0101, "R10 reset drive code", 32'(cpu_drv_o), 32'h5);
      check(cpustop_level_o == 1'b0, "R10 reset stop level", 32'(cpustop_level_o), 0);
      @(negedge clk);
      rst_n = 1'b1;
      mon_en = 1'b1;
      cpustop_n = 1'b1;
      pwrdn_n = 1'b1;
      settle_check("R5 all running");

      pwrdn_n = 1'b0;
      settle_check("R1 power-down driven");
      cpu_pd_hiz = 1'b1;
      settle_check("R1 power-down three-state");
      pwrdn_n = 1'b1;
      settle_check("R1 power restored");
      cpu_pd_hiz = 1'b0;

      cpustop_n = 1'b0;
      settle_check("R2 cpu stop");
      cpu_free = 2'b01;
      settle_check("R2 cpu1 free");
      cpu_free = 2'b10;
      settle_check("R2 cpu2 free");
      cpustop_n = 1'b1;
      cpu_free = '0;

      pcistop_n = 1'b0;
      settle_check("R3 pci stop, R4 free pci kept");
      pcif_stop_en = 3'b101;
      settle_check("R4 free pci selectively stopped");
      cpustop_n = 1'b0;
      settle_check("R5 both stops");
      defaults();

      cpu_oe = 2'b10; pcif_oe = 3'b011; pci_oe = 6'b100101;
      v66_oe = 2'b01; buf_oe = 3'b010; usb_oe = 1'b0; dot_oe = 1'b1;
      settle_check("R6 disabled outputs");
      defaults();
      settle_check("R6 re-enabled");

      // R9 latency of the stop level
      @(negedge clk);
      cpustop_n = 1'b0;
      @(posedge clk); #1;
      check(cpustop_level_o == 1'b1, "R9 level after one edge", 32'(cpustop_level_o), 1);
      @(posedge clk); #1;
      check(cpustop_level_o == 1'b0, "R9 level after two edges", 32'(cpustop_level_o), 0);
      cpustop_n = 1'b1;

      for (int it = 0; it < 40; it++) begin
         repeat ($urandom_range(0, 7)) @(negedge clk);
         pwrdn_n      = ($urandom_range(0, 3) != 0);
         cpustop_n    = $urandom_range(0, 1);
         pcistop_n    = $urandom_range(0, 1);
         cpu_oe       = NC'($urandom);
         cpu_free     = NC'($urandom);
         cpu_pd_hiz   = $urandom_range(0, 1);
         pcif_oe      = NF'($urandom);
         pcif_stop_en = NF'($urandom);
         pci_oe       = NP'($urandom);
         v66_oe       = NV'($urandom);
         buf_oe       = NB'($urandom);
         usb_oe       = $urandom_range(0, 1);
         dot_oe       = $urandom_range(0, 1);
         settle_check("RAND mix");
      end

      check(runts == 0, "R7 no shortened or late clock phase", 32'(runts), 0);
      check(bad_codes == 0, "R8 drive code 11 never seen", 32'(bad_codes), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule